// File: doc/BRIEF.md
# PCI read parity error reporter

This block watches read data that a target returns on one side of a two-port PCI bridge. On every clock where the initiator and target ready strobes are both low, it captures the 32-bit AD word and the four C/BE# lines. On the following clock it takes the PAR bit and checks even parity over all 37 bits. A mismatch always sets a sticky detected-error status bit. When the parity error response enable is set, it also sets a second sticky status bit and pulls an active-low PERR# output low.

The data, the byte enables and the parity bit exactly as received go toward the other bus, one clock after PAR arrives. Bad parity is never corrected, never regenerated and never used to stop the transfer. A data phase that was never transferred is never forwarded. The block ignores a PERR# that the initiator drives back on returned data. Software clears the status bits by pulsing a write-one-to-clear input for each bit.

Top module: `prr_read_parity_reporter`

## Requirements
- R1: A transferred data phase is in error when the XOR of AD[31:0], C/BE#[3:0] and PAR is 1. PAR is the `par_in` value sampled on the clock after that phase.
- R2: A data phase is transferred only on a clock where `irdy_n` and `trdy_n` are both sampled low. No other clock produces a parity check or a forwarded word.
- R3: When a phase taken at clock edge T has a parity error, and `perr_rsp_en` is 1 at edge T+1, `perr_n_o` is low at edge T+2.
- R4: Each PERR# event drives `perr_n_o` low for one clock, then high for one clock with `perr_oe` still 1, and then `perr_oe` drops to 0. Errors on consecutive phases keep `perr_n_o` low without a gap. `perr_oe` is 1 whenever `perr_n_o` is low.
- R5: `sts_det_perr` becomes 1 after every parity error, whatever the value of `perr_rsp_en`.
- R6: `sts_data_perr` becomes 1 after a parity error only if `perr_rsp_en` is 1 on the clock the error is detected.
- R7: A status bit clears when its clear input is 1 at an edge with no new error for that bit. If the clear and a new error come on the same edge, the bit stays 1.
- R8: For a phase transferred at edge T, the forwarded outputs hold at edge T+2: `fwd_valid`=1, `fwd_ad` and `fwd_cbe_n` equal to the values taken at T, and `fwd_par` equal to the PAR sampled at T+1. This holds whether the parity is good or bad. `fwd_valid` is 0 otherwise.
- R9: `init_perr_n` has no effect on any output.
- R10: During reset, `perr_n_o`=1, `perr_oe`=0, both status bits are 0 and `fwd_valid`=0.
- R11: With `perr_rsp_en` at 0, a parity error never pulls `perr_n_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Returned read data word |
| cbe_n_in | input | 4 | Byte enables of the data phase, active low |
| par_in | input | 1 | Parity bit, one clock behind its data phase |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| init_perr_n | input | 1 | PERR# seen from the initiator on returned data (ignored) |
| perr_rsp_en | input | 1 | Parity error response enable |
| clr_det_perr | input | 1 | Write-one-to-clear for the detected-error bit |
| clr_data_perr | input | 1 | Write-one-to-clear for the reported-error bit |
| sts_det_perr | output | 1 | Sticky: a parity error was detected |
| sts_data_perr | output | 1 | Sticky: a parity error was detected and reported |
| perr_n_o | output | 1 | PERR# drive value, active low |
| perr_oe | output | 1 | PERR# output enable |
| fwd_valid | output | 1 | Forwarded word valid this clock |
| fwd_ad | output | 32 | Forwarded data word |
| fwd_cbe_n | output | 4 | Forwarded byte enables |
| fwd_par | output | 1 | Forwarded received parity bit |

## Verification
A wrong capture register or parity fold first shows two edges after the transfer. At that point the forwarded word differs, or a status bit rises when it should not, or fails to rise when it should. The PERR# sequencer state is visible on every clock through the drive value and the output enable, so a stuck or skipped state shows within three clocks of the error. A sticky bit that loses its value, or that clears when it should not, shows on the edge after the clear. The bench compares every output against an independent model on each clock, so each of these faults is reported within that window.

// File: rtl/prr_pkg.sv
package prr_pkg;
  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_LOW  = 2'd1,
    PD_HIGH = 2'd2
  } perr_st_e;

  localparam int STS_DET  = 0;
  localparam int STS_DATA = 1;
  localparam int STS_N    = 2;
endpackage

// File: rtl/prr_phase_capture.sv
module prr_phase_capture #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_in,
  input  logic [BE_W-1:0] cbe_n_in,
  input  logic            par_in,
  input  logic            irdy_n,
  input  logic            trdy_n,
  output logic            xfer,
  output logic            ph_pend,
  output logic [AD_W-1:0] ph_ad,
  output logic [BE_W-1:0] ph_cbe_n,
  output logic            fwd_valid,
  output logic [AD_W-1:0] fwd_ad,
  output logic [BE_W-1:0] fwd_cbe_n,
  output logic            fwd_par
);
  assign xfer = !irdy_n && !trdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_pend   <= 1'b0;
      ph_ad     <= '0;
      ph_cbe_n  <= '0;
      fwd_valid <= 1'b0;
      fwd_ad    <= '0;
      fwd_cbe_n <= '0;
      fwd_par   <= 1'b0;
    end else begin
      ph_pend   <= xfer;
      if (xfer) begin
        ph_ad    <= ad_in;
        ph_cbe_n <= cbe_n_in;
      end
      fwd_valid <= ph_pend;
      if (ph_pend) begin
        fwd_ad    <= ph_ad;
        fwd_cbe_n <= ph_cbe_n;
        fwd_par   <= par_in;
      end
    end
  end

  // R8: data and byte enables forwarded unchanged two edges after transfer
  assert_fwd_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> ##1 (fwd_valid && fwd_ad == $past(ad_in, 2) && fwd_cbe_n == $past(cbe_n_in, 2)));
  // R8: received parity forwarded unchanged
  assert_fwd_par_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_pend |=> (fwd_par == $past(par_in)));
  // R2: no transfer, nothing forwarded
  assert_no_fwd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ##1 !fwd_valid);
endmodule

// File: rtl/prr_parity_check.sv
module prr_parity_check #(
  parameter int AD_W = 32,
  parameter int BE_W = 4
) (
  input  logic            ph_pend,
  input  logic [AD_W-1:0] ph_ad,
  input  logic [BE_W-1:0] ph_cbe_n,
  input  logic            par_in,
  output logic            chk_err
);
  function automatic logic odd_fold(input logic [AD_W-1:0] a,
                                    input logic [BE_W-1:0] b,
                                    input logic p);
    return ^{a, b, p};
  endfunction

  assign chk_err = ph_pend && odd_fold(ph_ad, ph_cbe_n, par_in);
endmodule

// File: rtl/prr_perr_drive.sv
module prr_perr_drive
  import prr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic err_en,
  output logic perr_n_o,
  output logic perr_oe
);
  perr_st_e st_q, st_d;

  always_comb begin
    if (err_en)              st_d = PD_LOW;
    else if (st_q == PD_LOW) st_d = PD_HIGH;
    else                     st_d = PD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PD_IDLE;
    else        st_q <= st_d;
  end

  assign perr_n_o = (st_q != PD_LOW);
  assign perr_oe  = (st_q != PD_IDLE);

  // R4: low is always driven
  assert_low_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_oe);
  // R4: a lone low is followed by a driven high
  assert_high_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n_o && !err_en) |=> (perr_n_o && perr_oe));
  // R4: driven high is followed by release
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_n_o && perr_oe && !err_en) |=> !perr_oe);
endmodule

// File: rtl/prr_status_bits.sv
module prr_status_bits #(
  parameter int N_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] set_vec,
  input  logic [N_BITS-1:0] clr_vec,
  output logic [N_BITS-1:0] sts_vec
);
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sts_vec[i] <= 1'b0;
      else if (set_vec[i]) sts_vec[i] <= 1'b1;
      else if (clr_vec[i]) sts_vec[i] <= 1'b0;
    end

    // R7: a new event wins over a simultaneous clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> sts_vec[i]);
    // R7: a clear with no event empties the bit
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !sts_vec[i]);
  end
endmodule

// File: rtl/prr_read_parity_reporter.sv
module prr_read_parity_reporter
  import prr_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_in,
  input  logic [AD_W/8-1:0] cbe_n_in,
  input  logic            par_in,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            init_perr_n,
  input  logic            perr_rsp_en,
  input  logic            clr_det_perr,
  input  logic            clr_data_perr,
  output logic            sts_det_perr,
  output logic            sts_data_perr,
  output logic            perr_n_o,
  output logic            perr_oe,
  output logic            fwd_valid,
  output logic [AD_W-1:0] fwd_ad,
  output logic [AD_W/8-1:0] fwd_cbe_n,
  output logic            fwd_par
);
  localparam int BE_W = AD_W / 8;

  logic              xfer;
  logic              ph_pend;
  logic [AD_W-1:0]   ph_ad;
  logic [BE_W-1:0]   ph_cbe_n;
  logic              chk_err;
  logic              err_report;
  logic [STS_N-1:0]  sts_set, sts_clr, sts_q;

  prr_phase_capture #(.AD_W(AD_W), .BE_W(BE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n_in(cbe_n_in),
    .par_in(par_in), .irdy_n(irdy_n), .trdy_n(trdy_n), .xfer(xfer),
    .ph_pend(ph_pend), .ph_ad(ph_ad), .ph_cbe_n(ph_cbe_n),
    .fwd_valid(fwd_valid), .fwd_ad(fwd_ad), .fwd_cbe_n(fwd_cbe_n),
    .fwd_par(fwd_par)
  );

  prr_parity_check #(.AD_W(AD_W), .BE_W(BE_W)) u_chk (
    .ph_pend(ph_pend), .ph_ad(ph_ad), .ph_cbe_n(ph_cbe_n),
    .par_in(par_in), .chk_err(chk_err)
  );

  assign err_report = chk_err && perr_rsp_en;

  prr_perr_drive u_drv (
    .clk(clk), .rst_n(rst_n), .err_en(err_report),
    .perr_n_o(perr_n_o), .perr_oe(perr_oe)
  );

  always_comb begin
    sts_set           = '0;
    sts_clr           = '0;
    sts_set[STS_DET]  = chk_err;
    sts_set[STS_DATA] = err_report;
    sts_clr[STS_DET]  = clr_det_perr;
    sts_clr[STS_DATA] = clr_data_perr;
  end

  prr_status_bits #(.N_BITS(STS_N)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_vec(sts_set), .clr_vec(sts_clr),
    .sts_vec(sts_q)
  );

  assign sts_det_perr  = sts_q[STS_DET];
  assign sts_data_perr = sts_q[STS_DATA];

  // R3: reported error drives PERR# low on the next edge
  assert_perr_two_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_report |=> !perr_n_o);
  // R3: PERR# only falls for a reported error
  assert_perr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_n_o) |-> $past(err_report));
  // R5: every error sets the detected bit
  assert_det_any_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |=> sts_det_perr);
  // R6: reported bit rises only with the enable set
  assert_dpd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_data_perr) |-> $past(chk_err && perr_rsp_en));
  // R11: with the enable off an error leaves PERR# high
  assert_quiet_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_err && !perr_rsp_en && perr_n_o) |=> perr_n_o);
  // R9: initiator PERR# alone never moves the detected bit
  assert_init_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_perr_n && !chk_err && !clr_det_perr) |=> $stable(sts_det_perr));
endmodule

// File: tb/tb_prr_read_parity_reporter.sv
`timescale 1ns/1ps
module tb_prr_read_parity_reporter;
  localparam int AD_W = 32;
  localparam int BE_W = AD_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AD_W-1:0] ad_in = '0;
  logic [BE_W-1:0] cbe_n_in = '0;
  logic par_in = 1'b0, irdy_n = 1'b1, trdy_n = 1'b1, init_perr_n = 1'b1;
  logic perr_rsp_en = 1'b0, clr_det_perr = 1'b0, clr_data_perr = 1'b0;
  logic sts_det_perr, sts_data_perr, perr_n_o, perr_oe, fwd_valid, fwd_par;
  logic [AD_W-1:0] fwd_ad;
  logic [BE_W-1:0] fwd_cbe_n;

  always #2 clk = ~clk;

  prr_read_parity_reporter #(.AD_W(AD_W)) dut (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n_in(cbe_n_in),
    .par_in(par_in), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .init_perr_n(init_perr_n), .perr_rsp_en(perr_rsp_en),
    .clr_det_perr(clr_det_perr), .clr_data_perr(clr_data_perr),
    .sts_det_perr(sts_det_perr), .sts_data_perr(sts_data_perr),
    .perr_n_o(perr_n_o), .perr_oe(perr_oe), .fwd_valid(fwd_valid),
    .fwd_ad(fwd_ad), .fwd_cbe_n(fwd_cbe_n), .fwd_par(fwd_par)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  bit m_pend = 0;
  logic [AD_W-1:0] m_ad = '0;
  logic [BE_W-1:0] m_cbe = '0;
  bit hist1 = 0, hist2 = 0;
  bit e_det = 0, e_dpd = 0, e_fv = 0, e_fp = 0;
  logic [AD_W-1:0] e_fad = '0;
  logic [BE_W-1:0] e_fcbe = '0;

  function automatic int ones(input logic [AD_W-1:0] a, input logic [BE_W-1:0] b);
    int n = 0;
    for (int i = 0; i < AD_W; i++) n += int'(a[i]);
    for (int i = 0; i < BE_W; i++) n += int'(b[i]);
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; hist1 = 0; hist2 = 0; e_det = 0; e_dpd = 0; e_fv = 0;
    end else begin
      bit e;
      e = m_pend && (((ones(m_ad, m_cbe) + int'(par_in)) % 2) == 1);
      hist2 = hist1;
      hist1 = e && perr_rsp_en;
      if (e) e_det = 1; else if (clr_det_perr) e_det = 0;
      if (e && perr_rsp_en) e_dpd = 1; else if (clr_data_perr) e_dpd = 0;
      e_fv = m_pend;
      if (m_pend) begin e_fad = m_ad; e_fcbe = m_cbe; e_fp = par_in; end
      m_pend = (irdy_n == 1'b0) && (trdy_n == 1'b0);
      m_ad = ad_in; m_cbe = cbe_n_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(perr_n_o == !hist1, "R3 R11 perr_n_o", 64'(perr_n_o), 64'(!hist1));
    chk(perr_oe == (hist1 || hist2), "R4 perr_oe", 64'(perr_oe), 64'(hist1 || hist2));
    chk(sts_det_perr == e_det, "R1 R5 sts_det_perr", 64'(sts_det_perr), 64'(e_det));
    chk(sts_data_perr == e_dpd, "R6 sts_data_perr", 64'(sts_data_perr), 64'(e_dpd));
    chk(fwd_valid == e_fv, "R2 fwd_valid", 64'(fwd_valid), 64'(e_fv));
    if (e_fv)
      chk({fwd_ad, fwd_cbe_n, fwd_par} == {e_fad, e_fcbe, e_fp}, "R8 forwarded word",
          64'({fwd_ad, fwd_cbe_n, fwd_par}), 64'({e_fad, e_fcbe, e_fp}));
  endtask

  // ---------------- stimulus ----------------
  bit next_par = 0;

  // one clock: compare, then drive the next input set
  task automatic step(input bit do_x, input bit flip, input bit cd, input bit cp);
    @(negedge clk);
    compare_all();
    par_in = next_par;
    ad_in = $urandom();
    cbe_n_in = BE_W'($urandom());
    irdy_n = do_x ? 1'b0 : 1'($urandom());
    trdy_n = do_x ? 1'b0 : 1'b1;
    clr_det_perr = cd;
    clr_data_perr = cp;
    init_perr_n = 1'($urandom());
    if (!irdy_n && !trdy_n)
      next_par = (ones(ad_in, cbe_n_in) % 2 == 1) ^ flip;
    else
      next_par = 1'($urandom());
  endtask

  task automatic random_run(input int n, input bit en);
    perr_rsp_en = en;
    for (int k = 0; k < n; k++)
      step(($urandom() % 3) != 0, ($urandom() % 10) < 3,
           ($urandom() % 10) == 0, ($urandom() % 10) == 0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(perr_n_o == 1'b1 && perr_oe == 1'b0, "R10 perr at reset", 64'({perr_n_o, perr_oe}), 64'h2);
    chk(sts_det_perr == 1'b0 && sts_data_perr == 1'b0, "R10 status at reset",
        64'({sts_det_perr, sts_data_perr}), 64'h0);
    chk(fwd_valid == 1'b0, "R10 fwd_valid at reset", 64'(fwd_valid), 64'h0);
    rst_n = 1'b1;

    random_run(400, 1'b1);

    // R4: three consecutive bad phases, then idle
    perr_rsp_en = 1'b1;
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0);

    random_run(400, 1'b0);

    // R7: clear on the same edge as a new error keeps the bits set
    perr_rsp_en = 1'b1;
    step(1, 1, 0, 0);          // bad phase transferred
    step(0, 0, 1, 1);          // clears sampled on the error edge
    step(0, 0, 0, 0);
    chk(sts_det_perr == 1'b1 && sts_data_perr == 1'b1, "R7 set beats clear",
        64'({sts_det_perr, sts_data_perr}), 64'h3);
    step(0, 0, 1, 1);
    step(0, 0, 0, 0);
    chk(sts_det_perr == 1'b0 && sts_data_perr == 1'b0, "R7 clear alone",
        64'({sts_det_perr, sts_data_perr}), 64'h0);

    // R9: initiator PERR# held low with no traffic changes nothing
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      compare_all();
      chk(perr_oe == 1'b0 && sts_det_perr == 1'b0 && sts_data_perr == 1'b0, "R9 initiator PERR# ignored",
          64'({perr_oe, sts_det_perr, sts_data_perr}), 64'h0);
      irdy_n = 1'b1; trdy_n = 1'b1; init_perr_n = 1'b0;
      clr_det_perr = 1'b0; clr_data_perr = 1'b0;
    end

    random_run(300, 1'b1);
    step(0, 0, 0, 0); step(0, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule